// File: doc/BRIEF.md
# Lockable Cartridge Bank Remapper

This block sits between a 68000-style CPU bus with a 24-bit byte address and the cartridge ROM and save RAM. It snoops writes into the lowest 64 KB of cartridge space and keeps one 8-bit control byte. When the enable bit of that byte is set, the 256 KB ROM bank at offset 0x380000 takes the place of the boot area at CPU address zero. The save RAM also gains a second window at 0x3C0000–0x3FFFFF, just below the 4 MB line, in addition to its normal window.

Address translation is purely combinational from the bus address and the stored control byte. For every read or write cycle it produces a ROM select with a translated ROM byte offset, or a save-RAM select with a 16-bit offset. A lock bit in the control byte freezes the mapping until the next reset. The bus pins are plain strobes with no valid/ready handshake. The block never stalls the CPU, and every access is decoded in the cycle it is presented.

Top module: `cart_bank_remap`

## Requirements
- R1: A control write is accepted only when its effective byte address is in 0x000000–0x00FFFF and bits [11:8] of that address equal 0xE. All other write strobes leave the mapping unchanged.
- R2: Once an accepted write has stored a byte with bit 5 set, every later control write is ignored until reset.
- R3: With control bit 7 set, CPU addresses 0x000000–0x03FFFF select ROM at offset 0x380000 plus the low 18 address bits. Address 0x040000 and above stay linear.
- R4: With control bit 7 set, CPU addresses 0x3C0000–0x3FFFFF select save RAM (ram_sel high, rom_sel low) with offset equal to the low 16 address bits. 0x3BFFFF remains ROM.
- R5: With control bit 7 clear, CPU addresses 0x000000–0x3FFFFF select ROM with offset equal to the CPU address, including the 0x3C0000 window.
- R6: CPU addresses 0x400000–0x40FFFF always select save RAM, with offset equal to the low 16 address bits.
- R7: A byte write (wr_word=0) uses wdata[7:0] at the given address. A 16-bit write (wr_word=1) is handled as a byte write of wdata[7:0] to address+1, so a word write at 0x000DFF is accepted and one at 0x00FFFF is not.
- R8: Reset clears the control byte, which gives linear mapping and no lock.
- R9: An accepted write changes the translation on the first clock edge after the strobe is sampled, and not before it.
- R10: Read strobes never change the control byte. With no strobe active, neither select is high. No address ever selects ROM and save RAM together. Addresses outside all windows select nothing.
- R11: Each accepted write replaces the whole control byte, so writing 0x00 after 0x80 restores linear mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | CPU byte address |
| bus_wdata | input | 16 | CPU write data; control byte taken from bits [7:0] |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | 1 = 16-bit write, 0 = byte write |
| rom_sel | output | 1 | ROM selected for this access |
| rom_addr | output | 22 | Translated ROM byte offset |
| ram_sel | output | 1 | Save RAM selected for this access |
| ram_off | output | 16 | Save-RAM byte offset |

## Verification
The bench aims at the decode edges. It probes a byte write at 0x000DFF against a word write there, whose odd target lands on 0x0E00, and a word write at 0x00FFFF, whose target falls outside the 64 KB range. A design that forgot the +1 would miss the first case or take the second. It reads both sides of each window edge (0x03FFFF/0x040000 and 0x3BFFFF/0x3C0000). An off-by-one bank compare would route those reads to the wrong device. It also sets enable and lock in one write, then tries to clear them. A lock that checked the incoming byte rather than the stored one, or that reset failed to clear, would show up as a mapping that changes or stays frozen. The update cycle is sampled before and after the clock edge to catch a combinational bypass.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ADDR_W   = 24;
  localparam int CTRL_W   = 8;
  localparam int EN_BIT   = 7;
  localparam int LOCK_BIT = 5;

  typedef logic [CTRL_W-1:0] ctrl_t;

  typedef struct packed {
    logic  hit;
    ctrl_t data;
  } ctrl_wr_t;
endpackage

// File: rtl/remap_wr_decode.sv
module remap_wr_decode
  import remap_pkg::*;
#(
  parameter int          SPAN_W  = 16,
  parameter logic [3:0]  SEL_NIB = 4'hE
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              wr_en,
  input  logic              wr_word,
  output ctrl_wr_t          wr
);
  localparam int HI_W = ADDR_W + 1 - SPAN_W;

  // One extra bit so address+1 at the top of the space cannot wrap into range
  logic [ADDR_W:0] eff_addr;
  logic            in_span;
  logic            nib_ok;

  always_comb begin
    eff_addr = {1'b0, addr} + {{ADDR_W{1'b0}}, wr_word};
    in_span  = (eff_addr[ADDR_W:SPAN_W] == {HI_W{1'b0}});
    nib_ok   = (eff_addr[11:8] == SEL_NIB);
    wr.hit   = wr_en && in_span && nib_ok;
    wr.data  = wdata[CTRL_W-1:0];
  end
endmodule

// File: rtl/remap_ctrl_reg.sv
module remap_ctrl_reg
  import remap_pkg::*;
#(
  parameter ctrl_t RESET_VAL = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ctrl_wr_t wr,
  output ctrl_t    ctrl_q
);
  logic locked;
  assign locked = ctrl_q[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= RESET_VAL;
    else if (wr.hit && !locked)
      ctrl_q <= wr.data;
  end
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
  import remap_pkg::*;
#(
  parameter int                ROM_AW      = 22,
  parameter int                BANK_AW     = 18,
  parameter logic [3:0]        BOOT_BANK   = 4'hE,
  parameter logic [ADDR_W-1:0] MIRROR_BASE = 24'h3C0000,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = 24'h400000,
  parameter int                SRAM_AW     = 16
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               access,
  input  ctrl_t              ctrl,
  output logic               rom_sel,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic               ram_sel,
  output logic [SRAM_AW-1:0] ram_off
);
  localparam int BANK_NUM_W = ROM_AW - BANK_AW;

  logic in_rom, in_boot, in_mirror, in_sram, enabled;

  always_comb begin
    enabled   = ctrl[EN_BIT];
    in_rom    = (addr[ADDR_W-1:ROM_AW] == '0);
    in_boot   = (addr[ADDR_W-1:BANK_AW] == '0);
    in_mirror = (addr[ADDR_W-1:BANK_AW] == MIRROR_BASE[ADDR_W-1:BANK_AW]);
    in_sram   = (addr[ADDR_W-1:SRAM_AW] == SRAM_BASE[ADDR_W-1:SRAM_AW]);

    rom_sel  = 1'b0;
    rom_addr = '0;
    ram_sel  = 1'b0;
    ram_off  = '0;

    if (access) begin
      if (in_sram || (enabled && in_mirror)) begin
        ram_sel = 1'b1;
        ram_off = addr[SRAM_AW-1:0];
      end else if (in_rom) begin
        rom_sel = 1'b1;
        if (enabled && in_boot)
          rom_addr = {BOOT_BANK[BANK_NUM_W-1:0], addr[BANK_AW-1:0]};
        else
          rom_addr = addr[ROM_AW-1:0];
      end
    end
  end
endmodule

// File: rtl/cart_bank_remap.sv
module cart_bank_remap
  import remap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic        wr_word,
  output logic        rom_sel,
  output logic [21:0] rom_addr,
  output logic        ram_sel,
  output logic [15:0] ram_off
);
  ctrl_wr_t wr_req;
  ctrl_t    ctrl_q;
  logic     access;

  assign access = rd_en | wr_en;

  remap_wr_decode #(.SPAN_W(16), .SEL_NIB(4'hE)) u_dec (
    .addr(bus_addr), .wdata(bus_wdata), .wr_en(wr_en),
    .wr_word(wr_word), .wr(wr_req)
  );

  remap_ctrl_reg #(.RESET_VAL('0)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr(wr_req), .ctrl_q(ctrl_q)
  );

  remap_xlate #(
    .ROM_AW(22), .BANK_AW(18), .BOOT_BANK(4'hE),
    .MIRROR_BASE(24'h3C0000), .SRAM_BASE(24'h400000), .SRAM_AW(16)
  ) u_xl (
    .addr(bus_addr), .access(access), .ctrl(ctrl_q),
    .rom_sel(rom_sel), .rom_addr(rom_addr),
    .ram_sel(ram_sel), .ram_off(ram_off)
  );
endmodule

// File: rtl/cart_bank_remap_chk.sv
module cart_bank_remap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] bus_addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  ctrl_q,
  input logic        rom_sel,
  input logic [21:0] rom_addr,
  input logic        ram_sel,
  input logic [15:0] ram_off
);
  assert_lock_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[5] |=> $stable(ctrl_q));

  assert_read_no_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

  assert_boot_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ctrl_q[7] && bus_addr < 24'h040000)
      |-> (rom_sel && rom_addr == {4'hE, bus_addr[17:0]}));

  assert_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ctrl_q[7] && bus_addr[23:18] == 6'h0F)
      |-> (ram_sel && !rom_sel && ram_off == bus_addr[15:0]));

  assert_linear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ctrl_q[7] && bus_addr < 24'h400000)
      |-> (rom_sel && !ram_sel && rom_addr == bus_addr[21:0]));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && ram_sel));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |-> (!rom_sel && !ram_sel));
endmodule

bind cart_bank_remap cart_bank_remap_chk u_chk (.*);

// File: tb/cart_bank_remap_tb.sv
module cart_bank_remap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, wr_word = 1'b0;
  logic        rom_sel, ram_sel;
  logic [21:0] rom_addr;
  logic [15:0] ram_off;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  cart_bank_remap u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_en(rd_en), .wr_en(wr_en), .wr_word(wr_word),
    .rom_sel(rom_sel), .rom_addr(rom_addr), .ram_sel(ram_sel), .ram_off(ram_off)
  );

  localparam logic [1:0] OP_RD = 2'd0, OP_WB = 2'd1, OP_WW = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [23:0] addr;
    logic [15:0] data;
    logic        rs;
    logic [21:0] ra;
    logic        ms;
    logic [15:0] mo;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 24'h000100, 16'h0000, 1'b1, 22'h000100, 1'b0, 16'h0000, 8'd8},  // R8 default linear
    '{OP_RD, 24'h3C0010, 16'h0000, 1'b1, 22'h3C0010, 1'b0, 16'h0000, 8'd5},  // R5 window is ROM
    '{OP_RD, 24'h400020, 16'h0000, 1'b0, 22'h000000, 1'b1, 16'h0020, 8'd6},  // R6 native save RAM
    '{OP_WB, 24'h000D01, 16'h0080, 1'b0, 22'h0,      1'b0, 16'h0,    8'd1},  // R1 wrong nibble
    '{OP_RD, 24'h000100, 16'h0000, 1'b1, 22'h000100, 1'b0, 16'h0000, 8'd1},
    '{OP_WB, 24'h010E01, 16'h0080, 1'b0, 22'h0,      1'b0, 16'h0,    8'd1},  // R1 above 64 KB
    '{OP_RD, 24'h000100, 16'h0000, 1'b1, 22'h000100, 1'b0, 16'h0000, 8'd1},
    '{OP_WB, 24'h000E01, 16'h0080, 1'b0, 22'h0,      1'b0, 16'h0,    8'd3},  // enable
    '{OP_RD, 24'h000100, 16'h0000, 1'b1, 22'h380100, 1'b0, 16'h0000, 8'd3},  // R3 boot bank
    '{OP_RD, 24'h03FFFF, 16'h0000, 1'b1, 22'h3BFFFF, 1'b0, 16'h0000, 8'd3},
    '{OP_RD, 24'h040000, 16'h0000, 1'b1, 22'h040000, 1'b0, 16'h0000, 8'd3},  // R3 edge
    '{OP_RD, 24'h3C1234, 16'h0000, 1'b0, 22'h000000, 1'b1, 16'h1234, 8'd4},  // R4 mirror
    '{OP_RD, 24'h3BFFFF, 16'h0000, 1'b1, 22'h3BFFFF, 1'b0, 16'h0000, 8'd4},
    '{OP_RD, 24'h3FFFFF, 16'h0000, 1'b0, 22'h000000, 1'b1, 16'hFFFF, 8'd4},
    '{OP_WW, 24'h000DFF, 16'h1200, 1'b0, 22'h0,      1'b0, 16'h0,    8'd7},  // R7 word -> 0x0E00
    '{OP_RD, 24'h000100, 16'h0000, 1'b1, 22'h000100, 1'b0, 16'h0000, 8'd11}, // R11 cleared
    '{OP_WB, 24'h000E00, 16'h5580, 1'b0, 22'h0,      1'b0, 16'h0,    8'd7},  // R7 byte low lane
    '{OP_RD, 24'h3C0000, 16'h0000, 1'b0, 22'h000000, 1'b1, 16'h0000, 8'd7},
    '{OP_WW, 24'h00FFFF, 16'h0000, 1'b0, 22'h0,      1'b0, 16'h0,    8'd7},  // R7 wraps out
    '{OP_RD, 24'h000000, 16'h0000, 1'b1, 22'h380000, 1'b0, 16'h0000, 8'd7},
    '{OP_WB, 24'h000EFF, 16'h00A0, 1'b0, 22'h0,      1'b0, 16'h0,    8'd2},  // enable + lock
    '{OP_RD, 24'h000004, 16'h0000, 1'b1, 22'h380004, 1'b0, 16'h0000, 8'd2},
    '{OP_WB, 24'h000E01, 16'h0000, 1'b0, 22'h0,      1'b0, 16'h0,    8'd2},  // R2 ignored
    '{OP_RD, 24'h000004, 16'h0000, 1'b1, 22'h380004, 1'b0, 16'h0000, 8'd2},
    '{OP_RD, 24'h500000, 16'h0000, 1'b0, 22'h000000, 1'b0, 16'h0000, 8'd10}  // R10 unmapped
  };

  function automatic logic [39:0] observed();
    return {rom_sel, rom_sel ? rom_addr : 22'h0, ram_sel, ram_sel ? ram_off : 16'h0};
  endfunction

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [23:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    rd_en     = (op == OP_RD);
    wr_en     = (op != OP_RD);
    wr_word   = (op == OP_WW);
  endtask

  task automatic idle();
    rd_en = 1'b0; wr_en = 1'b0; wr_word = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R10 idle", observed(), 40'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].op, VECS[i].addr, VECS[i].data);
      if (VECS[i].op == OP_RD) begin
        #2;
        check($sformatf("R%0d vec %0d", VECS[i].req, i), observed(),
              {VECS[i].rs, VECS[i].ra, VECS[i].ms, VECS[i].mo});
      end
    end
    @(negedge clk); idle();

    // R8: reset clears lock and enable
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(OP_RD, 24'h000004, 16'h0); #2;
    check("R8 reset linear", observed(), {1'b1, 22'h000004, 1'b0, 16'h0});

    // R9: write visible only after the edge
    @(negedge clk);
    drive(OP_WB, 24'h000E01, 16'h0080); #2;
    check("R9 before edge", observed(), {1'b1, 22'h000E01, 1'b0, 16'h0});
    @(posedge clk); #2;
    check("R9 after edge", observed(), {1'b1, 22'h380E01, 1'b0, 16'h0});

    // R10: read with write-like data at the control address changes nothing
    @(negedge clk);
    drive(OP_RD, 24'h000E01, 16'h0000);
    @(negedge clk);
    drive(OP_RD, 24'h000010, 16'h0000); #2;
    check("R10 read no update", observed(), {1'b1, 22'h380010, 1'b0, 16'h0});

    // R8: lock released by reset, writes accepted again
    @(negedge clk);
    drive(OP_WB, 24'h000E01, 16'h0000);
    @(negedge clk);
    drive(OP_RD, 24'h000010, 16'h0000); #2;
    check("R8 unlocked after reset", observed(), {1'b1, 22'h000010, 1'b0, 16'h0});

    @(negedge clk); idle(); #2;
    check("R10 no access", observed(), 40'h0);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule